// File: doc/BRIEF.md
# Serial Eight-Tap FIR Filter

This block is an eight-tap finite impulse response filter built around one multiply-accumulate unit. The same multiplier is used for every tap, one tap per clock cycle. This gives up throughput in exchange for area and power. The coefficients and the sample history share one 16-word storage array. Words 0 to 7 hold the coefficients and words 8 to 15 hold the last eight samples as a circular buffer. The array has two read ports, so one coefficient and one sample are fetched together in each cycle.

Samples enter through a valid/ready stream, and results leave through a second valid/ready stream. Each accepted sample starts a fixed sequence of ten cycles:

- one cycle writes the sample into the history;
- eight cycles multiply and accumulate;
- one cycle presents the result.

A separate write port loads coefficients, but only while the filter is waiting for input. A one-bit idle output tells a system power manager when the filter is neither computing, nor taking a sample, nor holding a result. The manager can then gate or slow the block.

Top module: `serial_fir8`

## Requirements
- R1: A result equals sat16((sum over k = 0..7 of c[k] * x[n-k]) >>> 15). Here c[k] is coefficient word k, x[n] is the newest sample and x[n-k] is the k-th older one. Samples, coefficients and results are 16-bit two's complement. The shift is arithmetic, so it rounds toward minus infinity.
- R2: After reset, in_ready is 1, out_valid is 0 and idle is 1 (with in_valid low). All coefficients and all stored samples read as zero.
- R3: in_ready is high only while the filter waits for input. After a sample is accepted, in_ready stays low until that sample's result has been taken.
- R4: out_valid first rises at the ninth rising clock edge after the edge that accepted the sample. That edge starts the tenth cycle of the sequence.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: A coefficient write (coef_we with coef_addr 0..7 selecting c[k]) takes effect only while in_ready is high. When in_ready is low, the write is ignored and later results use the old value.
- R7: idle is 1 exactly when the filter waits for input and in_valid is low. It is 0 during the write, multiply and present cycles.
- R8: A shifted sum above 32767 gives 32767, and one below -32768 gives -32768.
- R9: The history keeps only the eight newest samples. Once more than eight samples have arrived, the oldest one no longer contributes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Filter will take a sample at this edge |
| out_valid | output | 1 | Result available |
| out_data | output | 16 | Signed saturated result |
| out_ready | input | 1 | Consumer takes the result at this edge |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index k |
| coef_data | input | 16 | Signed coefficient value |
| idle | output | 1 | Block has no activity this cycle |

## Verification
An impulse followed by zeros reads the coefficients back in tap order. This separates correct tap-to-sample pairing from reversed or shifted indexing. More than eight samples expose an incorrect wrap of the circular pointer. A single negative sample against a unit coefficient checks that the shift rounds toward minus infinity rather than truncating. Full-scale runs of both signs check each saturation limit. Back-pressured results check that the output is held. A coefficient write issued mid-computation must leave later results unchanged, and a long pseudo-random run with varied coefficients checks everything together.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOAD = 2'd1,
        ST_MAC  = 2'd2,
        ST_SHOW = 2'd3
    } fir_state_e;

endpackage

// File: rtl/fir_ram.sv
module fir_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [DW-1:0]            rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [DW-1:0]            rdata_b
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem_q[$past(waddr)] == $past(wdata)) // R9
        else $error("stored word differs from written data");

    logic [AW-1:0] unused_aw;
    assign unused_aw = '0;

endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int DW    = 16,
    parameter int ACC_W = 35,
    parameter int FRAC  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [DW-1:0] coef,
    input  logic [DW-1:0] sample,
    output logic [DW-1:0] result
);
    localparam int PW = 2 * DW;
    localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'((2 ** (DW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
    } mac_s;

    mac_s r_q, r_d;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] scaled;

    assign prod     = $signed(coef) * $signed(sample);
    assign prod_ext = {{(ACC_W - PW){prod[PW-1]}}, prod};

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.acc = '0;
        end else if (en) begin
            r_d.acc = r_q.acc + prod_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        scaled = r_q.acc >>> FRAC;
        if (scaled > SAT_HI) begin
            result = SAT_HI[DW-1:0];
        end else if (scaled < SAT_LO) begin
            result = SAT_LO[DW-1:0];
        end else begin
            result = scaled[DW-1:0];
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> r_q.acc == '0) // R1
        else $error("accumulator not cleared");

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !clr && !en |=> $stable(r_q.acc)) // R5
        else $error("accumulator moved while idle");

endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
    import fir_pkg::*;
#(
    parameter int TAPS = 8,
    parameter int DW   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DW-1:0]             in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    input  logic                      out_ready,
    input  logic                      coef_we,
    input  logic [$clog2(TAPS)-1:0]   coef_addr,
    input  logic [DW-1:0]             coef_data,
    output logic                      ram_we,
    output logic [$clog2(TAPS):0]     ram_waddr,
    output logic [DW-1:0]             ram_wdata,
    output logic [$clog2(TAPS):0]     ram_raddr_coef,
    output logic [$clog2(TAPS):0]     ram_raddr_smp,
    output logic                      mac_clr,
    output logic                      mac_en,
    output logic                      idle
);
    localparam int PTR_W = $clog2(TAPS);
    localparam logic [PTR_W-1:0] LAST_TAP = PTR_W'(TAPS - 1);

    typedef struct packed {
        fir_state_e       state;
        logic [PTR_W-1:0] ptr;
        logic [PTR_W-1:0] tap;
        logic [DW-1:0]    sample;
    } ctrl_s;

    ctrl_s r_q, r_d;

    always_comb begin
        r_d       = r_q;
        ram_we    = 1'b0;
        ram_waddr = '0;
        ram_wdata = '0;
        mac_clr   = 1'b0;
        mac_en    = 1'b0;
        unique case (r_q.state)
            ST_WAIT: begin
                ram_we    = coef_we;
                ram_waddr = {1'b0, coef_addr};
                ram_wdata = coef_data;
                if (in_valid) begin
                    r_d.sample = in_data;
                    r_d.state  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                ram_we    = 1'b1;
                ram_waddr = {1'b1, r_q.ptr};
                ram_wdata = r_q.sample;
                mac_clr   = 1'b1;
                r_d.tap   = '0;
                r_d.state = ST_MAC;
            end
            ST_MAC: begin
                mac_en = 1'b1;
                if (r_q.tap == LAST_TAP) begin
                    r_d.state = ST_SHOW;
                end else begin
                    r_d.tap = r_q.tap + PTR_W'(1);
                end
            end
            ST_SHOW: begin
                if (out_ready) begin
                    r_d.ptr   = r_q.ptr + PTR_W'(1);
                    r_d.state = ST_WAIT;
                end
            end
            default: r_d.state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_WAIT;
            r_q.ptr    <= '0;
            r_q.tap    <= '0;
            r_q.sample <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ram_raddr_coef = {1'b0, r_q.tap};
    assign ram_raddr_smp  = {1'b1, r_q.ptr - r_q.tap};
    assign in_ready       = (r_q.state == ST_WAIT);
    assign out_valid      = (r_q.state == ST_SHOW);
    assign idle           = in_ready && !in_valid;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready) // R3
        else $error("second sample could be taken while busy");

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid) // R5
        else $error("result dropped before it was taken");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !out_valid && !mac_en && !in_valid) // R7
        else $error("idle flagged during activity");

    AST_BUSY_COEF_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && !in_ready |-> ram_waddr[PTR_W]) // R6
        else $error("coefficient word written while busy");

endmodule

// File: rtl/serial_fir8.sv
module serial_fir8 #(
    parameter int TAPS  = 8,
    parameter int DW    = 16,
    parameter int ACC_W = 35,
    parameter int FRAC  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DW-1:0]           in_data,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic [DW-1:0]           out_data,
    input  logic                    out_ready,
    input  logic                    coef_we,
    input  logic [$clog2(TAPS)-1:0] coef_addr,
    input  logic [DW-1:0]           coef_data,
    output logic                    idle
);
    localparam int PTR_W = $clog2(TAPS);
    localparam int AW    = PTR_W + 1;
    localparam int DEPTH = 2 * TAPS;
    localparam int LAT_W = $clog2(TAPS + 4) + 1;
    localparam logic [LAT_W-1:0] LAT_EXP = LAT_W'(TAPS + 1);

    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [DW-1:0] ram_wdata;
    logic [AW-1:0] raddr_coef;
    logic [AW-1:0] raddr_smp;
    logic [DW-1:0] coef_rd;
    logic [DW-1:0] smp_rd;
    logic          mac_clr;
    logic          mac_en;

    fir_ctrl #(.TAPS(TAPS), .DW(DW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .coef_we        (coef_we),
        .coef_addr      (coef_addr),
        .coef_data      (coef_data),
        .ram_we         (ram_we),
        .ram_waddr      (ram_waddr),
        .ram_wdata      (ram_wdata),
        .ram_raddr_coef (raddr_coef),
        .ram_raddr_smp  (raddr_smp),
        .mac_clr        (mac_clr),
        .mac_en         (mac_en),
        .idle           (idle)
    );

    fir_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .raddr_a (raddr_coef),
        .rdata_a (coef_rd),
        .raddr_b (raddr_smp),
        .rdata_b (smp_rd)
    );

    fir_mac #(.DW(DW), .ACC_W(ACC_W), .FRAC(FRAC)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mac_clr),
        .en     (mac_en),
        .coef   (coef_rd),
        .sample (smp_rd),
        .result (out_data)
    );

    // Cycle counter since the last accepted sample, used only by the check below.
    logic [LAT_W-1:0] lat_q, lat_d;

    always_comb begin
        lat_d = lat_q;
        if (in_valid && in_ready) begin
            lat_d = '0;
        end else if (lat_q != '1) begin
            lat_d = lat_q + LAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '1;
        end else begin
            lat_q <= lat_d;
        end
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> lat_q == LAT_EXP) // R4
        else $error("result appeared at the wrong cycle");

    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(out_data)) // R5
        else $error("result changed while waiting");

endmodule

// File: tb/serial_fir8_bench.sv
module serial_fir8_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;
    logic        coef_we = 1'b0;
    logic [2:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;
    logic        idle;

    always #2 clk = ~clk;

    serial_fir8 u_serial_fir8 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready),
        .coef_we   (coef_we),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .idle      (idle)
    );

    int     n_tests = 0;
    int     n_fail  = 0;
    longint cyc     = 0;
    int     coef_m [8];
    int     hist_m [8];
    int     ptr_m   = 0;
    int     exp_q [$];
    longint acc_q [$];
    int     stall_len = 0;
    int     hold_cnt  = 0;
    string  cur_req   = "R1";
    bit     done      = 1'b0;
    bit     prev_v    = 1'b0;
    bit     prev_r    = 1'b0;
    logic [15:0] prev_d = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sat_ref(longint a);
        longint s = a >>> 15;
        if (s > 32767)  return 32767;
        if (s < -32768) return -32768;
        return int'(s);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic send(int x);
        longint acc;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'(x);
        while (!in_ready) @(negedge clk);
        hist_m[ptr_m] = int'($signed(16'(x)));
        acc = 0;
        for (int k = 0; k < 8; k++) begin
            acc += longint'(coef_m[k]) * longint'(hist_m[(ptr_m - k + 8) % 8]);
        end
        ptr_m = (ptr_m + 1) % 8;
        exp_q.push_back(sat_ref(acc));
        acc_q.push_back(cyc + 1);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        check(in_ready == 1'b0, "R3", int'(in_ready), 0);
        check(idle == 1'b0, "R7", int'(idle), 0);
    endtask

    task automatic load_coef(int a, int v);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = 3'(a);
        coef_data = 16'(v);
        if (in_ready) coef_m[a] = int'($signed(16'(v)));
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: holds results for stall_len cycles, then compares against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (!prev_v) begin
                    hold_cnt = 0;
                    if (acc_q.size() != 0)
                        check(cyc == acc_q[0] + 9, "R4", int'(cyc - acc_q[0]), 9);
                end else if (!prev_r) begin
                    check(out_data == prev_d, "R5", int'($signed(out_data)),
                          int'($signed(prev_d)));
                end
                check(idle == 1'b0, "R7", int'(idle), 0);
                out_ready = (hold_cnt >= stall_len);
                hold_cnt++;
                if (out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, cur_req, int'($signed(out_data)), 0);
                    end else begin
                        check($signed(out_data) == 16'(exp_q[0]), cur_req,
                              int'($signed(out_data)), exp_q[0]);
                        void'(exp_q.pop_front());
                        void'(acc_q.pop_front());
                    end
                end
            end else begin
                out_ready = 1'b0;
            end
            prev_v = out_valid;
            prev_r = out_ready;
            prev_d = out_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lfsr;
        for (int i = 0; i < 8; i++) begin
            coef_m[i] = 0;
            hist_m[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R2", int'(in_ready), 1);
        check(out_valid == 1'b0, "R2", int'(out_valid), 0);
        check(idle == 1'b1, "R2", int'(idle), 1);

        // R2: coefficients reset to zero, so the first result is zero
        cur_req = "R2";
        send(12345);
        drain();
        check(idle == 1'b1, "R7", int'(idle), 1);

        // R1 and R9: impulse reads back coefficients, then the history wraps
        for (int k = 0; k < 8; k++) load_coef(k, (k + 1) * 1024 - 3000);
        cur_req = "R1";
        send(16384);
        for (int i = 0; i < 7; i++) send(0);
        cur_req = "R9";
        for (int i = 0; i < 4; i++) send(-20000 + i * 9000);
        drain();

        // R1: the shift rounds toward minus infinity
        for (int k = 0; k < 8; k++) load_coef(k, (k == 0) ? 1 : 0);
        cur_req = "R1";
        send(-1);
        send(1);
        drain();

        // R8: saturation at both limits
        for (int k = 0; k < 8; k++) load_coef(k, 32767);
        cur_req = "R8";
        for (int i = 0; i < 8; i++) send(32767);
        for (int i = 0; i < 8; i++) send(-32768);
        drain();

        // R5: results held under back-pressure
        for (int k = 0; k < 8; k++) load_coef(k, 4000 - k * 1100);
        cur_req = "R5";
        stall_len = 3;
        for (int i = 0; i < 4; i++) send(7000 * (i + 1) - 12000);
        drain();
        stall_len = 0;

        // R6: a coefficient write during computation is ignored
        cur_req = "R6";
        send(8000);
        load_coef(0, 30000);
        check(coef_m[0] == 4000, "R6", coef_m[0], 4000);
        send(16000);
        send(-8000);
        drain();

        // Mixed pseudo-random run with varying back-pressure
        cur_req = "R1";
        lfsr = 32'h1ACE;
        for (int k = 0; k < 8; k++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            load_coef(k, (lfsr >>> 8) % 65536 - 32768);
        end
        for (int i = 0; i < 20; i++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
            stall_len = i % 3;
            send((lfsr >>> 8) % 65536 - 32768);
        end
        drain();
        stall_len = 0;
        check(idle == 1'b1, "R7", int'(idle), 1);

        finish_run();
    end

endmodule